// File: doc/BRIEF.md
# Full-Speed USB Host Clock Generator

This block derives the two full-speed host clocks from either of two PLL sources. Each source arrives as a one-cycle strobe in the system clock domain, and each strobe marks one edge of that PLL clock. A configuration register holds two fields. The first is a source-select bit. The second is a 4-bit divider field, where a value of N divides the chosen source by N+1. The main output, the nominal 48 MHz clock, toggles once every N+1 strobes, so its duty cycle is always 50%. The companion 12 MHz output is that clock divided by four.

Software turns the clock on and off to save power while the host is idle. It uses a write-one-to-set register and a write-one-to-clear register. A status register reports the live state of the gate. Changes to the source or the divider are held as pending values. They move into the running divider only at a terminal count, or at once while the clock is stopped. As a result, no output phase is ever cut short. The gate opens and closes only while both outputs are low.

Top module: `usb_fs_clkgen`

## Requirements
- R1: After reset both outputs are 0, the status bit reads 0, and the configuration register reads 0 (select 0, divider 0).
- R2: A write to address 0 with data bit 0 set requests the clock on. The status bit (address 2, bit 0) reads 1 two clock cycles after the write cycle.
- R3: A write to address 1 with data bit 0 set removes the request. The gate then closes at the terminal count that returns both outputs to low, and the status bit then reads 0.
- R4: Writes to address 0 or 1 with data bit 0 clear change nothing. The status bit and the outputs carry on as before.
- R5: While the clock runs, clk48_o toggles on every (N+1)-th strobe of the selected source, where N is the active divider field. It does not change otherwise.
- R6: Configuration bit 4 selects the source: 0 selects pll_a_tick and 1 selects pll_u_tick. Strobes from the source that is not selected have no effect on the outputs.
- R7: clk12_o changes only on a falling edge of clk48_o, on every second such edge. Its period is therefore four clk48_o periods, with 50% duty.
- R8: A new select or divider value written to address 3 (bits 3:0 divider, bit 4 select) takes effect only at a terminal count, or right away while the clock is stopped.
- R9: While the gate is closed both outputs are 0, and the gate never closes while either output is high.
- R10: A read of address 3 returns the last written configuration. A read of address 2 returns the gate state in bit 0, with all other bits 0. Reads of addresses 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_a_tick | input | 1 | Edge strobe of the first PLL source |
| pll_u_tick | input | 1 | Edge strobe of the USB PLL source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 set, 1 clear, 3 configuration |
| wr_data | input | 5 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 5 | Combinational read data |
| clk48_o | output | 1 | Divided full-speed clock, nominally 48 MHz |
| clk12_o | output | 1 | Companion clock, nominally 12 MHz |

## Verification
On every cycle, the assertions check the following: the outputs are low while the gate is closed; a pending request opens the gate on the next cycle; the gate falls only when the request has been removed; clk48_o holds between terminal counts; clk12_o moves only on a falling clk48_o; and the active configuration is frozen away from load points. Some behaviours can only be shown by the bench's scenarios, which run against its cycle model. These are the exact toggle spacing for each divider value, the ignored strobes of the unselected source, a mid-run divider and source change landing on a terminal count, and register readback.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;
  localparam int DIV_W_DEF    = 4;
  localparam int SLOW_LOG2    = 2;
  localparam int ADDR_W       = 2;
  localparam logic [ADDR_W-1:0] ADR_ON   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_OFF  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 2'd3;
endpackage

// File: rtl/usbclk_regs.sv
module usbclk_regs
  import usbclk_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEF,
  localparam int DATA_W = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              run_i,
  output logic              en_req_o,
  output logic              pend_sel_o,
  output logic [DIV_W-1:0]  pend_div_o
);
  logic set_hit, clr_hit, cfg_hit;

  assign set_hit = wr_en && (wr_addr == ADR_ON)  && wr_data[0];
  assign clr_hit = wr_en && (wr_addr == ADR_OFF) && wr_data[0];
  assign cfg_hit = wr_en && (wr_addr == ADR_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req_o   <= 1'b0;
      pend_sel_o <= 1'b0;
      pend_div_o <= '0;
    end else begin
      if (set_hit)      en_req_o <= 1'b1;
      else if (clr_hit) en_req_o <= 1'b0;
      if (cfg_hit) begin
        pend_sel_o <= wr_data[DIV_W];
        pend_div_o <= wr_data[DIV_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_STAT: rd_data[0] = run_i;
      ADR_CFG:  rd_data    = {pend_sel_o, pend_div_o};
      default:  rd_data    = '0;
    endcase
  end
endmodule

// File: rtl/usbclk_divider.sv
module usbclk_divider #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_a_tick,
  input  logic             pll_u_tick,
  input  logic             run_i,
  input  logic             pend_sel_i,
  input  logic [DIV_W-1:0] pend_div_i,
  output logic             tc_o,
  output logic             cfg_load_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             act_sel_o,
  output logic [DIV_W-1:0] act_div_o
);
  logic [DIV_W-1:0] cnt;
  logic             src_tick;

  function automatic logic at_limit(input logic [DIV_W-1:0] c,
                                    input logic [DIV_W-1:0] lim);
    return c == lim;
  endfunction

  assign src_tick   = act_sel_o ? pll_u_tick : pll_a_tick;
  assign tc_o       = run_i && src_tick && at_limit(cnt, act_div_o);
  assign cfg_load_o = tc_o || !run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      phase_o   <= '0;
      act_sel_o <= 1'b0;
      act_div_o <= '0;
    end else begin
      if (run_i && src_tick) cnt <= tc_o ? '0 : cnt + 1'b1;
      if (tc_o) phase_o <= phase_o + 1'b1;
      if (cfg_load_o) begin
        act_sel_o <= pend_sel_i;
        act_div_o <= pend_div_i;
      end
    end
  end
endmodule

// File: rtl/usbclk_gate.sv
module usbclk_gate #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_req_i,
  input  logic            tc_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            run_o,
  output logic            wrap_o
);
  assign wrap_o = tc_i && (phase_i == {PH_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_o <= 1'b0;
    else if (!run_o && en_req_i)         run_o <= 1'b1;
    else if (run_o && !en_req_i && wrap_o) run_o <= 1'b0;
  end
endmodule

// File: rtl/usb_fs_clkgen.sv
module usb_fs_clkgen
  import usbclk_pkg::*;
#(
  parameter int DIV_W     = DIV_W_DEF,
  parameter int SLOW_SHFT = SLOW_LOG2,
  localparam int DATA_W   = DIV_W + 1,
  localparam int PH_W     = SLOW_SHFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_a_tick,
  input  logic              pll_u_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk48_o,
  output logic              clk12_o
);
  logic             en_req, pend_sel, act_sel, gate_run, tc, cfg_load, wrap;
  logic [DIV_W-1:0] pend_div, act_div;
  logic [PH_W-1:0]  phase;

  usbclk_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .run_i(gate_run), .en_req_o(en_req), .pend_sel_o(pend_sel),
    .pend_div_o(pend_div)
  );

  usbclk_divider #(.DIV_W(DIV_W), .PH_W(PH_W)) u_div (
    .clk(clk), .rst_n(rst_n), .pll_a_tick(pll_a_tick),
    .pll_u_tick(pll_u_tick), .run_i(gate_run), .pend_sel_i(pend_sel),
    .pend_div_i(pend_div), .tc_o(tc), .cfg_load_o(cfg_load),
    .phase_o(phase), .act_sel_o(act_sel), .act_div_o(act_div)
  );

  usbclk_gate #(.PH_W(PH_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .tc_i(tc),
    .phase_i(phase), .run_o(gate_run), .wrap_o(wrap)
  );

  assign clk48_o = phase[0];
  assign clk12_o = phase[PH_W-1];
endmodule

// File: rtl/usbclk_checker.sv
module usbclk_checker #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk48,
  input logic             clk12,
  input logic             run,
  input logic             en_req,
  input logic             tc,
  input logic             cfg_load,
  input logic             act_sel,
  input logic [DIV_W-1:0] act_div
);
  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!clk48 && !clk12)); // R9
  AST_OPEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && en_req) |=> run); // R2
  AST_CLOSE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(!en_req)); // R3
  AST_HOLD_48: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(clk48)); // R5
  AST_SLOW_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk12) || $fell(clk12)) |-> $fell(clk48)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(act_div) && $stable(act_sel))); // R8
endmodule

bind usb_fs_clkgen usbclk_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk48(clk48_o), .clk12(clk12_o),
  .run(gate_run), .en_req(en_req), .tc(tc), .cfg_load(cfg_load),
  .act_sel(act_sel), .act_div(act_div)
);

// File: tb/usb_fs_clkgen_test.sv
module usb_fs_clkgen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_tick = 1'b0, u_tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic clk48, clk12;

  int checks = 0, errors = 0;
  int a_mode = 0, u_mode = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model state
  int m_cnt, m_tog, m_adiv, m_pdiv;
  bit m_asel, m_psel, m_run, m_en;

  usb_fs_clkgen uut (
    .clk(clk), .rst_n(rst_n), .pll_a_tick(a_tick), .pll_u_tick(u_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk48_o(clk48), .clk12_o(clk12)
  );

  always #5 clk = ~clk;

  function automatic bit gen_tick(int mode, int cyc);
    case (mode)
      1: return 1'b1;
      2: return cyc % 2 == 0;
      3: return 1'($urandom_range(0, 1));
      default: return 1'b0;
    endcase
  endfunction

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    a_tick <= gen_tick(a_mode, cyc);
    u_tick <= gen_tick(u_mode, cyc);
  end

  always @(posedge clk) begin
    bit tk, tc, run_was, en_was;
    if (!rst_n) begin
      m_cnt = 0; m_tog = 0; m_adiv = 0; m_pdiv = 0;
      m_asel = 0; m_psel = 0; m_run = 0; m_en = 0;
    end else begin
      run_was = m_run; en_was = m_en; tc = 0;
      tk = m_asel ? u_tick : a_tick;
      if (run_was && tk) begin
        if (m_cnt == m_adiv) begin tc = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (tc || !run_was) begin m_asel = m_psel; m_adiv = m_pdiv; end
      if (!run_was && en_was) m_run = 1;
      else if (run_was && !en_was && tc && (m_tog % 8 == 7)) m_run = 0;
      if (tc) m_tog++;
      if (wr_en) begin
        if (wr_addr == 2'd0 && wr_data[0]) m_en = 1;
        if (wr_addr == 2'd1 && wr_data[0]) m_en = 0;
        if (wr_addr == 2'd3) begin m_psel = wr_data[4]; m_pdiv = int'(wr_data[3:0]); end
      end
    end
  end

  function automatic logic [4:0] exp_rd();
    case (rd_addr)
      2'd2: return {4'b0, m_run};
      2'd3: return {m_psel, 4'(m_pdiv)};
      default: return 5'd0;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from both edges
  always @(posedge clk) begin
    #4;
    if (rst_n && !done) begin
      check(cur_req, "clk48", int'(clk48), m_tog % 2);
      check(cur_req, "clk12", int'(clk12), int'((m_tog % 8) >= 4));
      check(cur_req, "rd_data", int'(rd_data), int'(exp_rd()));
    end
  end

  task automatic bus_wr(logic [1:0] a, logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    cur_req = "R1";
    check("R1", "clk48 reset", int'(clk48), 0);
    check("R1", "clk12 reset", int'(clk12), 0);
    rd_addr = 2'd2; #1 check("R1", "status reset", int'(rd_data), 0);
    rd_addr = 2'd3; #1 check("R1", "config reset", int'(rd_data), 0);

    // R10: configuration readback, divide by 2 from source A
    cur_req = "R10";
    bus_wr(2'd3, 5'b0_0001);
    rd_addr = 2'd3; #1 check("R10", "config readback", int'(rd_data), 1);
    rd_addr = 2'd0; #1 check("R10", "set reads zero", int'(rd_data), 0);

    // R2: enable, status after two cycles
    cur_req = "R2";
    rd_addr = 2'd2;
    a_mode = 1; u_mode = 3;
    bus_wr(2'd0, 5'b0_0001);
    idle(1); #1 check("R2", "status on", int'(rd_data), 1);

    // R5 R6 R7: run from source A, random noise on source U
    cur_req = "R5";
    idle(40);
    cur_req = "R7";
    idle(40);

    // R4: zero-bit writes to set and clear
    cur_req = "R4";
    bus_wr(2'd1, 5'b1_1110);
    idle(20);
    #1 check("R4", "status after zero clear", int'(rd_data), 1);

    // R8: divider change mid-run, source A pattern every other cycle
    cur_req = "R8";
    a_mode = 2;
    bus_wr(2'd3, 5'b0_0011);
    idle(80);

    // R6: switch to source U, A keeps toggling randomly
    cur_req = "R6";
    a_mode = 3; u_mode = 2;
    bus_wr(2'd3, 5'b1_0010);
    idle(100);

    // R3 R9: clear and wait for gate to close on a low phase
    cur_req = "R3";
    bus_wr(2'd1, 5'b0_0001);
    for (int i = 0; i < 300 && rd_data[0]; i++) idle(1);
    #1 check("R3", "status off", int'(rd_data), 0);
    cur_req = "R9";
    check("R9", "clk48 stopped", int'(clk48), 0);
    check("R9", "clk12 stopped", int'(clk12), 0);
    idle(20);

    // R4: zero-bit set while stopped
    cur_req = "R4";
    bus_wr(2'd0, 5'b1_1110);
    idle(10);
    #1 check("R4", "status after zero set", int'(rd_data), 0);
    check("R4", "clk48 still low", int'(clk48), 0);

    // R5: normal divide by 10 from source A, then stop
    cur_req = "R5";
    u_mode = 1; a_mode = 1;
    bus_wr(2'd3, 5'b0_1001);
    bus_wr(2'd0, 5'b0_0001);
    idle(400);
    bus_wr(2'd3, 5'b1_0000);
    cur_req = "R8";
    idle(100);
    cur_req = "R3";
    bus_wr(2'd1, 5'b0_0001);
    idle(60);
    #1 check("R3", "status off at end", int'(rd_data), 0);
    finish_run();
  end
endmodule